// File: doc/BRIEF.md
# Floating-Point Add/Subtract Accumulator

This block keeps a 48-bit floating-point accumulator. It loads it from an operand, stores it out, and adds an operand to it or subtracts an operand from it. The operand arrives as two 24-bit words on `in_hi`/`in_lo`. A store returns the accumulator in the same two-word layout on `out_hi`/`out_lo`. The value is a 38-bit two's-complement fraction in the range [-1, 1), scaled by two to the power of a 9-bit exponent. The exponent is held with its sign bit inverted, which is the same as an offset of 256. A sticky exponent-overflow flag sits in the top bit of the lower word.

A request is a one-cycle `start` with an operation code `opc` and three modifier bits `mods`. Load and store complete at once. Add and subtract run as a short sequence:

1. The fraction with the smaller exponent is shifted right one place per clock, keeping one guard bit.
2. The two fractions are combined.
3. A temporary fraction overflow is corrected.
4. The result is normalized one place per clock.
5. The result is rounded.
6. The result is written back.

The modifiers turn off rounding and normalization, or reverse the subtraction. Load and store use modifier bit 0 to load zeros or to clear the accumulator after a store. A result whose exponent falls to -256 clears the value and keeps the flag.

Top module: `fpacc_unit`

## Requirements
- R1: Word layout. `hi[23:0]` holds fraction bits 37..14, and bit 37 is the sign. In `lo`, bit 23 is the overflow flag, bits 22..9 hold fraction bits 13..0, and bits 8..0 hold the exponent plus 256 (code 0 means -256). A load followed by a store returns the loaded words unchanged.
- R2: Load is `opc`=00. It copies the operand into the accumulator, and the flag takes the operand's bit 23 of `lo`. With `mods[0]`=1 it loads all zeros and clears the flag.
- R3: Store is `opc`=01. It presents the accumulator with the flag on `out_hi`/`out_lo` while `done` is high. `ovf_pulse` is high in that same cycle exactly when the flag is set. With `mods[0]`=1 the accumulator and flag are cleared after the words are taken.
- R4: Add is `opc`=10 and gives acc+operand. Subtract is `opc`=11 and gives acc-operand. With `mods[2]`=1, subtract gives operand-acc instead. `mods[2]` has no effect on add.
- R5: Before combining, the operand with the smaller exponent is shifted right until the exponents match. Unnormalized operands are accepted. A sum that is exactly representable comes out exact.
- R6: When the combined fraction leaves [-1, 1), it is shifted right by one and the exponent rises by one.
- R7: By default the result is shifted left until fraction bits 37 and 36 differ, lowering the exponent each step. `mods[1]`=1 leaves the result unnormalized.
- R8: By default one half unit of the last place is added, using the guard bit. An overflow caused by rounding is corrected by a right shift and an exponent increment. `mods[0]`=1 truncates instead.
- R9: An exponent increment past +255 sets the flag and holds the exponent code at 511. An operand flag bit on add or subtract also sets the flag. The flag clears only through load or store-and-clear.
- R10: An arithmetic result whose final exponent code is 0 (-256 or below) has its fraction and exponent cleared, and the flag is kept. This includes a zero sum that is normalized.
- R11: `busy` is high from the cycle after an accepted add/subtract until the result is written. `done` is a single-cycle pulse in the cycle after the accumulator update. For load and store, that update is the accepting edge. A `start` while busy is ignored.
- R12: After reset the accumulator, exponent code and flag are zero, and `busy`, `done` and `ovf_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe |
| opc | input | 2 | Operation: 00 load, 01 store, 10 add, 11 subtract |
| mods | input | 3 | Modifiers: bit0 no-round/zero/clear, bit1 no-normalize, bit2 reverse |
| in_hi | input | 24 | Operand upper word |
| in_lo | input | 24 | Operand lower word |
| busy | output | 1 | Arithmetic in progress |
| done | output | 1 | Completion pulse |
| out_hi | output | 24 | Stored upper word |
| out_lo | output | 24 | Stored lower word |
| ovf_pulse | output | 1 | Overflow report with a store |

## Verification
The assertions assume that `start` is a single-cycle strobe and that nothing but load and store-and-clear may lower the overflow flag. They also assume that the only way the exponent code ends at 0 with a nonzero fraction is a direct load, never an arithmetic write-back. The bench drives `start` for one cycle only, at a negative edge. It waits for `done` before issuing the next request, except in the one case that deliberately fires a load into a busy engine. The operand sweep uses small integers with exact encodings, so the guard bit stays zero there. Rounding, saturation and underflow are reached through hand-built words.

// File: rtl/fpacc_pkg.sv
package fpacc_pkg;

    parameter int FRAC_W = 38;
    parameter int EXP_W  = 9;
    parameter int WORD_W = 24;

    // fraction bits carried by the lower word
    localparam int LO_FRAC = FRAC_W - WORD_W;
    // working width: one headroom bit, the fraction, one guard bit
    localparam int EXT_W   = FRAC_W + 2;

    localparam logic [EXP_W-1:0] EXP_TOP  = '1;
    localparam logic [EXP_W-1:0] EXP_ZERO = '0;

    typedef logic [EXT_W-1:0]  ext_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [EXP_W-1:0]  expc_t;

    typedef enum logic [1:0] {
        OPC_LOAD  = 2'b00,
        OPC_STORE = 2'b01,
        OPC_ADD   = 2'b10,
        OPC_SUB   = 2'b11
    } opc_e;

    // mods[2] reverse, mods[1] no normalize, mods[0] no round / zero / clear
    typedef struct packed {
        logic reverse;
        logic no_norm;
        logic no_round;
    } mods_t;

    typedef struct packed {
        logic  ovf;
        frac_t frac;
        expc_t expc;
    } fpval_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } fpword_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_SUM,
        ST_NORM,
        ST_ROUND,
        ST_WRITE
    } eng_st_e;

    function automatic fpval_t unpack_words(input logic [WORD_W-1:0] hi,
                                            input logic [WORD_W-1:0] lo);
        fpval_t v;
        v.ovf  = lo[WORD_W-1];
        v.frac = {hi, lo[WORD_W-2 -: LO_FRAC]};
        v.expc = lo[EXP_W-1:0];
        return v;
    endfunction

    function automatic fpword_t pack_value(input fpval_t v);
        fpword_t w;
        w.hi = v.frac[FRAC_W-1 -: WORD_W];
        w.lo = {v.ovf, v.frac[LO_FRAC-1:0], v.expc};
        return w;
    endfunction

    function automatic ext_t widen(input frac_t f);
        return {f[FRAC_W-1], f, 1'b0};
    endfunction

    function automatic ext_t shr1(input ext_t x);
        return {x[EXT_W-1], x[EXT_W-1:1]};
    endfunction

    // fraction has left [-1,1): headroom and sign disagree
    function automatic logic spills(input ext_t x);
        return x[EXT_W-1] ^ x[EXT_W-2];
    endfunction

    function automatic logic is_normal(input ext_t x);
        return x[EXT_W-2] ^ x[EXT_W-3];
    endfunction

endpackage

// File: rtl/fpacc_codec.sv
module fpacc_codec
    import fpacc_pkg::*;
(
    input  logic [WORD_W-1:0] in_hi,
    input  logic [WORD_W-1:0] in_lo,
    input  fpval_t            acc,
    output fpval_t            opnd,
    output fpword_t           acc_words
);

    assign opnd      = unpack_words(in_hi, in_lo);
    assign acc_words = pack_value(acc);

endmodule

// File: rtl/fpacc_arith.sv
module fpacc_arith
    import fpacc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  logic   is_sub,
    input  mods_t  mods,
    input  fpval_t acc_in,
    input  fpval_t opnd_in,
    output logic   busy,
    output logic   res_valid,
    output fpval_t res
);

    eng_st_e state;
    ext_t    xa, xb, wv;
    expc_t   ea, eb, ew;
    logic    ovf_w;
    mods_t   mods_q;
    logic    sub_q;

    ext_t    sum_v, rnd_v;
    logic    ea_sat, ew_sat;
    expc_t   ea_up, ew_up;

    always_comb begin
        if (!sub_q)
            sum_v = xa + xb;
        else if (mods_q.reverse)
            sum_v = xb - xa;
        else
            sum_v = xa - xb;
        rnd_v  = wv + ext_t'(1);
        ea_sat = (ea == EXP_TOP);
        ew_sat = (ew == EXP_TOP);
        ea_up  = ea_sat ? ea : ea + 1'b1;
        ew_up  = ew_sat ? ew : ew + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            xa     <= '0;
            xb     <= '0;
            wv     <= '0;
            ea     <= '0;
            eb     <= '0;
            ew     <= '0;
            ovf_w  <= 1'b0;
            mods_q <= '0;
            sub_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        xa     <= widen(acc_in.frac);
                        xb     <= widen(opnd_in.frac);
                        ea     <= acc_in.expc;
                        eb     <= opnd_in.expc;
                        ovf_w  <= acc_in.ovf | opnd_in.ovf;
                        mods_q <= mods;
                        sub_q  <= is_sub;
                        state  <= ST_ALIGN;
                    end
                end
                ST_ALIGN: begin
                    if (ea == eb) begin
                        state <= ST_SUM;
                    end else if (ea > eb) begin
                        xb <= shr1(xb);
                        eb <= eb + 1'b1;
                    end else begin
                        xa <= shr1(xa);
                        ea <= ea + 1'b1;
                    end
                end
                ST_SUM: begin
                    if (spills(sum_v)) begin
                        wv <= shr1(sum_v);
                        ew <= ea_up;
                        if (ea_sat)
                            ovf_w <= 1'b1;
                    end else begin
                        wv <= sum_v;
                        ew <= ea;
                    end
                    state <= ST_NORM;
                end
                ST_NORM: begin
                    if (mods_q.no_norm || is_normal(wv) || ew == EXP_ZERO) begin
                        state <= ST_ROUND;
                    end else begin
                        wv <= wv << 1;
                        ew <= ew - 1'b1;
                    end
                end
                ST_ROUND: begin
                    if (!mods_q.no_round) begin
                        if (spills(rnd_v)) begin
                            wv <= shr1(rnd_v);
                            ew <= ew_up;
                            if (ew_sat)
                                ovf_w <= 1'b1;
                        end else begin
                            wv <= rnd_v;
                        end
                    end
                    state <= ST_WRITE;
                end
                ST_WRITE: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        res_valid = (state == ST_WRITE);
        res.ovf   = ovf_w;
        res.expc  = ew;
        res.frac  = (ew == EXP_ZERO) ? '0 : wv[EXT_W-2:1];
    end

endmodule

// File: rtl/fpacc_unit.sv
module fpacc_unit
    import fpacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        opc,
    input  logic [2:0]        mods,
    input  logic [WORD_W-1:0] in_hi,
    input  logic [WORD_W-1:0] in_lo,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] out_hi,
    output logic [WORD_W-1:0] out_lo,
    output logic              ovf_pulse
);

    fpval_t  acc_q;
    fpval_t  opnd;
    fpval_t  res;
    fpword_t acc_words;
    fpword_t out_q;
    logic    done_q, pulse_q;
    logic    eng_busy, res_valid, accept, go;
    mods_t   mods_s;
    opc_e    opc_s;

    assign mods_s = mods_t'(mods);
    assign opc_s  = opc_e'(opc);
    assign accept = start && !eng_busy;
    assign go     = accept && opc[1];

    fpacc_codec i_codec (
        .in_hi     (in_hi),
        .in_lo     (in_lo),
        .acc       (acc_q),
        .opnd      (opnd),
        .acc_words (acc_words)
    );

    fpacc_arith i_arith (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .is_sub    (opc[0]),
        .mods      (mods_s),
        .acc_in    (acc_q),
        .opnd_in   (opnd),
        .busy      (eng_busy),
        .res_valid (res_valid),
        .res       (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            out_q   <= '0;
            done_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            pulse_q <= 1'b0;
            if (res_valid) begin
                acc_q  <= res;
                done_q <= 1'b1;
            end else if (accept) begin
                case (opc_s)
                    OPC_LOAD: begin
                        acc_q  <= mods_s.no_round ? '0 : opnd;
                        done_q <= 1'b1;
                    end
                    OPC_STORE: begin
                        out_q   <= acc_words;
                        pulse_q <= acc_q.ovf;
                        if (mods_s.no_round)
                            acc_q <= '0;
                        done_q  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy      = eng_busy;
    assign done      = done_q;
    assign out_hi    = out_q.hi;
    assign out_lo    = out_q.lo;
    assign ovf_pulse = pulse_q;

endmodule

// File: rtl/fpacc_checker.sv
module fpacc_checker
    import fpacc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              arith_op,
    input logic              busy,
    input logic              done,
    input logic              ovf_pulse,
    input logic              acc_ovf,
    input logic [FRAC_W-1:0] acc_frac,
    input logic [EXP_W-1:0]  acc_expc
);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_end_signalled_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_acc_held_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable({acc_ovf, acc_frac, acc_expc}));

    assert_pulse_on_done_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> done);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(acc_ovf) |-> $past(start && !busy && !arith_op));

    assert_underflow_clear_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && acc_expc == '0) |-> acc_frac == '0);

endmodule

bind fpacc_unit fpacc_checker i_fpacc_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .arith_op  (opc[1]),
    .busy      (busy),
    .done      (done),
    .ovf_pulse (ovf_pulse),
    .acc_ovf   (acc_q.ovf),
    .acc_frac  (acc_q.frac),
    .acc_expc  (acc_q.expc)
);

// File: tb/test_fpacc_unit.sv
module test_fpacc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  opc = 2'b00;
    logic [2:0]  mods = 3'b000;
    logic [23:0] in_hi = '0;
    logic [23:0] in_lo = '0;
    logic        busy, done, ovf_pulse;
    logic [23:0] out_hi, out_lo;

    int total = 0;
    int bad = 0;

    localparam logic [1:0] LD = 2'b00, ST = 2'b01, AD = 2'b10, SB = 2'b11;

    always #5 clk = ~clk;

    fpacc_unit i_fpacc_unit (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .opc       (opc),
        .mods      (mods),
        .in_hi     (in_hi),
        .in_lo     (in_lo),
        .busy      (busy),
        .done      (done),
        .out_hi    (out_hi),
        .out_lo    (out_lo),
        .ovf_pulse (ovf_pulse)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // two-word encoding per R1
    function automatic logic [47:0] enc(input longint f, input int e, input bit ov);
        logic [37:0] fr;
        logic [8:0]  ec;
        fr = f[37:0];
        ec = e[8:0];
        return {fr[37:14], ov, fr[13:0], ec};
    endfunction

    function automatic int klen(input longint m);
        for (int k = 0; k < 40; k++)
            if (m < (longint'(1) <<< k) && m >= -(longint'(1) <<< k))
                return k;
        return 40;
    endfunction

    function automatic logic [47:0] norm_enc(input longint m);
        int k;
        if (m == 0) return enc(0, 0, 0);
        k = klen(m);
        return enc(m <<< (37 - k), k + 256, 0);
    endfunction

    function automatic logic [47:0] raw_enc(input longint a, input longint b, input longint s);
        int ka, kb, e;
        if (a == 0 && b == 0) return enc(0, 0, 0);
        ka = (a == 0) ? -256 : klen(a);
        kb = (b == 0) ? -256 : klen(b);
        e  = (ka > kb) ? ka : kb;
        if (s >= (longint'(1) <<< e) || s < -(longint'(1) <<< e)) e++;
        return enc(s <<< (37 - e), e + 256, 0);
    endfunction

    task automatic issue(input logic [1:0] o, input logic [2:0] m, input logic [47:0] w,
                         output logic [47:0] got, output logic pulse);
        int n;
        n = 0;
        @(negedge clk);
        opc = o; mods = m; {in_hi, in_lo} = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (!done) check("R11 completion", 64'd0, 64'd1);
        got   = {out_hi, out_lo};
        pulse = ovf_pulse;
    endtask

    task automatic op(input logic [1:0] o, input logic [2:0] m, input logic [47:0] w);
        logic [47:0] g;
        logic p;
        issue(o, m, w, g, p);
    endtask

    task automatic expect_acc(input string req, input logic [47:0] exp, input logic exp_p);
        logic [47:0] g;
        logic p;
        issue(ST, 3'b000, '0, g, p);
        check(req, {15'd0, p, g}, {15'd0, exp_p, exp});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint H;
        logic [47:0] g;
        logic p;
        H = longint'(1) <<< 36;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 busy/done/pulse", {61'd0, busy, done, ovf_pulse}, 64'd0);
        expect_acc("R12 reset accumulator", 48'd0, 1'b0);

        // R1 round trip and R2/R3 flag
        op(LD, 3'b000, {24'hA5A5A5, 24'h3CF123});
        expect_acc("R1 round trip", {24'hA5A5A5, 24'h3CF123}, 1'b0);
        op(LD, 3'b000, {24'h5A0F0F, 24'hBCF123});
        expect_acc("R2 R3 flag loaded and reported", {24'h5A0F0F, 24'hBCF123}, 1'b1);

        // R2 load zeros
        op(LD, 3'b001, {24'h123456, 24'hFFFFFF});
        expect_acc("R2 load zeros", 48'd0, 1'b0);

        // R3 store and clear
        op(LD, 3'b000, {24'h400001, 24'h812345});
        issue(ST, 3'b001, '0, g, p);
        check("R3 store-clear output", {15'd0, p, g}, {15'd0, 1'b1, 24'h400001, 24'h812345});
        expect_acc("R3 cleared after store", 48'd0, 1'b0);

        // R11 load completes next cycle
        @(negedge clk);
        opc = LD; mods = 3'b000; {in_hi, in_lo} = norm_enc(5); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 load done timing", {62'd0, done, busy}, 64'd2);

        // R11 start ignored while busy
        @(negedge clk);
        opc = AD; {in_hi, in_lo} = norm_enc(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11 busy after add start", {63'd0, busy}, 64'd1);
        opc = LD; {in_hi, in_lo} = norm_enc(7); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        expect_acc("R11 ignored start", norm_enc(8), 1'b0);

        // R4 reverse ignored on add
        op(LD, 3'b000, norm_enc(5));
        op(AD, 3'b100, norm_enc(3));
        expect_acc("R4 reverse on add", norm_enc(8), 1'b0);

        // R5 unnormalized operand
        op(LD, 3'b000, enc(longint'(1) <<< 30, 266, 0));
        op(AD, 3'b000, norm_enc(1));
        expect_acc("R5 unnormalized operand", norm_enc(9), 1'b0);

        // R6 fraction overflow correction
        op(LD, 3'b000, enc(H, 300, 0));
        op(AD, 3'b000, enc(H, 300, 0));
        expect_acc("R6 overflow correction", enc(H, 301, 0), 1'b0);

        // R8 rounding with guard bit
        op(LD, 3'b000, enc(H + 1, 300, 0));
        op(AD, 3'b000, enc(H + 1, 301, 0));
        expect_acc("R8 rounded", enc(3 * (H >>> 1) + 2, 301, 0), 1'b0);
        op(LD, 3'b000, enc(H + 1, 300, 0));
        op(AD, 3'b001, enc(H + 1, 301, 0));
        expect_acc("R8 truncated", enc(3 * (H >>> 1) + 1, 301, 0), 1'b0);

        // R8 rounding overflow
        op(LD, 3'b000, enc(2 * H - 1, 301, 0));
        op(AD, 3'b000, enc(1, 300, 0));
        expect_acc("R8 round overflow", enc(H, 302, 0), 1'b0);
        op(LD, 3'b000, enc(2 * H - 1, 301, 0));
        op(AD, 3'b001, enc(1, 300, 0));
        expect_acc("R8 truncated max", enc(2 * H - 1, 301, 0), 1'b0);

        // R9 exponent overflow
        op(LD, 3'b000, enc(H, 511, 0));
        op(AD, 3'b000, enc(H, 511, 0));
        expect_acc("R9 exponent overflow", enc(H, 511, 1), 1'b1);
        expect_acc("R9 flag sticky over store", enc(H, 511, 1), 1'b1);
        op(LD, 3'b000, enc(H, 300, 0));
        expect_acc("R9 R2 load clears flag", enc(H, 300, 0), 1'b0);
        op(AD, 3'b000, enc(H, 300, 1));
        expect_acc("R9 operand flag", enc(H, 301, 1), 1'b1);

        // R10 underflow keeps flag
        op(LD, 3'b000, enc(H, 1, 1));
        op(SB, 3'b000, enc(H >>> 1, 1, 0));
        expect_acc("R10 underflow clear", enc(0, 0, 1), 1'b1);

        // sweep over small integers
        for (int a = -10; a <= 10; a++) begin
            for (int b = -10; b <= 10; b++) begin
                op(LD, 3'b000, norm_enc(a));
                op(AD, 3'b000, norm_enc(b));
                expect_acc("R4 R5 R7 R10 add", norm_enc(a + b), 1'b0);
                op(LD, 3'b000, norm_enc(a));
                op(SB, 3'b000, norm_enc(b));
                expect_acc("R4 R5 R7 R10 sub", norm_enc(a - b), 1'b0);
                op(LD, 3'b000, norm_enc(a));
                op(SB, 3'b100, norm_enc(b));
                expect_acc("R4 reversed sub", norm_enc(b - a), 1'b0);
                op(LD, 3'b000, norm_enc(a));
                op(AD, 3'b010, norm_enc(b));
                expect_acc("R7 R6 unnormalized add", raw_enc(a, b, a + b), 1'b0);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule